// File: doc/BRIEF.md
# Serial CRC-4 Encoder and Checker

This block divides a serial bit stream by the polynomial D^4 + D + 1, one bit per accepted clock, using a four-stage shift register with feedback. In generate mode it takes an 8-bit message and produces four check bits. The encoder then appends these check bits to the message, highest stage first. In check mode it takes a received 12-bit block, made of eight data bits followed by four check bits, and reports whether the division leaves a remainder.

A frame opens with a one-cycle start pulse, which also samples the mode select. Bits arrive highest-degree coefficient first, each one qualified by a valid strobe. After the last bit of the frame the block pulses a done flag. It then holds the remainder, and in check mode an error flag, until the next start pulse.

Top module: `crc4_serial_unit`

## Requirements
- R1: While reset (active low) is applied and after it is released, crc_o is 0000, done_o is 0 and err_o is 0.
- R2: The clock edge that samples start_i high clears crc_o, done_o and err_o and latches the mode (mode_chk_i 0 = generate, 1 = check). A start during a frame abandons that frame and begins a new one.
- R3: A bit is taken only on an edge where a frame is open, bit_vld_i is 1 and start_i is 0. Bits enter highest-degree coefficient first. A bit presented with start_i is ignored.
- R4: In generate mode, after 8 taken bits crc_o holds the remainder of message·D^4 divided by D^4+D+1. crc_o[3] is CRC3, the first appended bit, and crc_o[0] is CRC0, the last. The message 10110110 yields 1011.
- R5: In check mode, after 12 taken bits crc_o holds the remainder of the 12-bit block divided by D^4+D+1, and err_o is 1 exactly when that remainder is nonzero. Three blocks are fixed: 101101101011 gives 0000 with err_o 0; flipping its sixth bit gives 1100 with err_o 1; flipping its CRC1 bit gives 0010 with err_o 1.
- R6: done_o is high for exactly the one cycle that follows the edge taking the 8th bit (generate) or the 12th bit (check). It is low at all other times.
- R7: In generate mode err_o stays 0.
- R8: Once a frame has finished, crc_o and err_o keep their values until the next start, whatever bit_vld_i and bit_i do.
- R9: While a frame is in progress, crc_o shows the remainder for the bits taken so far, under the rule of the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a frame and samples the mode |
| mode_chk_i | input | 1 | 0 = generate check bits, 1 = check a received block |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies bit_i |
| crc_o | output | 4 | Running remainder; bit 3 is CRC3 |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| err_o | output | 1 | Nonzero remainder in check mode |

## Verification
Every result is one register away from its stimulus. The edge that takes a bit updates crc_o for the next cycle. The edge that takes the last bit of a frame raises done_o and sets err_o for that same next cycle. A start clears all three outputs at its own edge. The reference model in the bench advances on the same rising edges from the same inputs. The bench compares outputs against the model and makes its fixed-value checks on the falling edge, half a period after the edge that should have produced the change.

// File: rtl/crc4_serial_unit.sv
module crc4_serial_unit #(
  parameter int MSG_BITS = 8,
  parameter int POLY_W = 4,
  parameter logic [POLY_W-1:0] POLY_LOW = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_chk_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic [POLY_W-1:0] crc_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int BLK_BITS = MSG_BITS + POLY_W;
  localparam int CNT_W = $clog2(BLK_BITS + 1);
  localparam logic [CNT_W-1:0] GEN_LAST = CNT_W'(MSG_BITS - 1);
  localparam logic [CNT_W-1:0] CHK_LAST = CNT_W'(BLK_BITS - 1);

  logic [POLY_W-1:0] rem_q, rem_next, gen_next, chk_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, chk_q, done_q, err_q;

  wire take     = busy_q & bit_vld_i & ~start_i;
  wire last_bit = cnt_q == (chk_q ? CHK_LAST : GEN_LAST);
  wire fb_gen   = rem_q[POLY_W-1] ^ bit_i;

  assign gen_next = {rem_q[POLY_W-2:0], 1'b0} ^ ({POLY_W{fb_gen}} & POLY_LOW);
  assign chk_next = {rem_q[POLY_W-2:0], bit_i} ^ ({POLY_W{rem_q[POLY_W-1]}} & POLY_LOW);
  assign rem_next = chk_q ? chk_next : gen_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      chk_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      chk_q  <= mode_chk_i;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        rem_q <= rem_next;
        cnt_q <= cnt_q + 1'b1;
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= chk_q & (|rem_next);
        end
      end
    end
  end

  assign crc_o  = rem_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/crc4_serial_unit_chk.sv
module crc4_serial_unit_chk #(
  parameter int MSG_BITS = 8,
  parameter int POLY_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mode_chk_i,
  input logic              bit_vld_i,
  input logic [POLY_W-1:0] crc_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int CW = $clog2(MSG_BITS + POLY_W + 1);
  logic          c_busy, c_mode;
  logic [CW-1:0] c_cnt;

  wire c_last = c_busy && bit_vld_i && !start_i &&
                (c_cnt == CW'((c_mode ? MSG_BITS + POLY_W : MSG_BITS) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_busy <= 1'b0; c_mode <= 1'b0; c_cnt <= '0;
    end else if (start_i) begin
      c_busy <= 1'b1; c_mode <= mode_chk_i; c_cnt <= '0;
    end else if (c_busy && bit_vld_i) begin
      c_cnt <= c_cnt + 1'b1;
      if (c_last) c_busy <= 1'b0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (rst_n || (crc_o == '0 && !done_o && !err_o)));
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> (crc_o == '0 && !done_o && !err_o));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_n) c_last |=> done_o);
  a_r6_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n) !c_last |=> !done_o);
  a_r7_gen_no_err: assert property (@(posedge clk) disable iff (!rst_n) !c_mode |-> !err_o);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n) (!c_busy && !start_i) |=> ($stable(crc_o) && $stable(err_o)));
endmodule

bind crc4_serial_unit crc4_serial_unit_chk #(.MSG_BITS(MSG_BITS), .POLY_W(POLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_chk_i(mode_chk_i),
  .bit_vld_i(bit_vld_i), .crc_o(crc_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_crc4_serial_unit.sv
module tb_crc4_serial_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_chk_i = 1'b0, bit_i = 1'b0, bit_vld_i = 1'b0;
  logic [3:0] crc_o;
  logic done_o, err_o;
  int n_cmp = 0, n_bad = 0;

  crc4_serial_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_chk_i(mode_chk_i),
    .bit_i(bit_i), .bit_vld_i(bit_vld_i), .crc_o(crc_o), .done_o(done_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] polymod(input logic [15:0] v, input int nbits);
    logic [15:0] w = v;
    for (int i = nbits - 1; i >= 4; i--)
      if (w[i]) w = w ^ (16'b10011 << (i - 4));
    return w[3:0];
  endfunction

  logic        m_busy, m_mode, m_done, m_err;
  logic [3:0]  m_crc;
  logic [15:0] m_bits;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_mode <= 0; m_done <= 0; m_err <= 0; m_crc <= 0; m_bits <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (start_i) begin
        m_busy <= 1; m_mode <= mode_chk_i; m_err <= 0; m_crc <= 0; m_bits <= 0; m_cnt <= 0;
      end else if (m_busy && bit_vld_i) begin
        logic [15:0] nb;
        logic [3:0]  r;
        int          nc;
        nb = {m_bits[14:0], bit_i};
        nc = m_cnt + 1;
        r = m_mode ? polymod(nb, nc) : polymod(nb << 4, nc + 4);
        m_bits <= nb; m_cnt <= nc; m_crc <= r;
        if (nc == (m_mode ? 12 : 8)) begin
          m_busy <= 0; m_done <= 1; m_err <= m_mode && (r != 0);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check("R6 done_o", {3'b0, done_o}, {3'b0, m_done});
    check("R4 R5 R9 crc_o", crc_o, m_crc);
    check("R5 R7 err_o", {3'b0, err_o}, {3'b0, m_err});
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      start_i = 0; bit_vld_i = 0; bit_i = $urandom_range(0, 1);
    end
  endtask

  task automatic begin_frame(input logic chk, input logic with_bit);
    @(negedge clk);
    start_i = 1; mode_chk_i = chk; bit_vld_i = with_bit; bit_i = 1;
  endtask

  task automatic feed(input logic [11:0] pat, input int n, input bit gaps);
    for (int i = n - 1; i >= 0; i--) begin
      if (gaps && ($urandom_range(0, 2) == 0)) begin
        @(negedge clk);
        start_i = 0; bit_vld_i = 0; bit_i = ~pat[i];
      end
      @(negedge clk);
      start_i = 0; bit_vld_i = 1; bit_i = pat[i];
    end
    @(negedge clk);
    bit_vld_i = 0;
  endtask

  task automatic run(input logic chk, input logic [11:0] pat, input bit gaps);
    begin_frame(chk, 1'b0);
    feed(pat, chk ? 12 : 8, gaps);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 crc_o in reset", crc_o, 4'b0000);
    check("R1 done/err in reset", {2'b0, done_o, err_o}, 4'b0000);
    @(negedge clk); rst_n = 1;
    idle(2);
    check("R1 crc_o after reset", crc_o, 4'b0000);

    run(1'b0, 12'b0000_1011_0110, 1'b0);
    check("R4 codeword check bits", crc_o, 4'b1011);
    check("R6 done after 8th bit", {3'b0, done_o}, 4'b0001);
    check("R7 err_o in generate", {3'b0, err_o}, 4'b0000);

    bit_vld_i = 1; idle(0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); bit_vld_i = 1; bit_i = i[0];
    end
    @(negedge clk); bit_vld_i = 0;
    check("R8 crc_o held after frame", crc_o, 4'b1011);

    run(1'b1, 12'b1011_0110_1011, 1'b1);
    check("R5 clean codeword remainder", crc_o, 4'b0000);
    check("R5 clean codeword err", {3'b0, err_o}, 4'b0000);

    run(1'b1, 12'b1011_0010_1011, 1'b0);
    check("R5 sixth bit flipped remainder", crc_o, 4'b1100);
    check("R5 sixth bit flipped err", {3'b0, err_o}, 4'b0001);
    idle(3);
    check("R8 err_o held", {3'b0, err_o}, 4'b0001);

    begin_frame(1'b0, 1'b0);
    @(negedge clk); start_i = 0;
    check("R2 start clears err and crc", {err_o, crc_o[2:0]}, 4'b0000);

    run(1'b1, 12'b1011_0110_1001, 1'b1);
    check("R5 CRC1 flipped remainder", crc_o, 4'b0010);
    check("R5 CRC1 flipped err", {3'b0, err_o}, 4'b0001);

    run(1'b1, 12'b0000_0111_0001, 1'b0);
    run(1'b1, 12'b0000_1111_0001, 1'b0);
    run(1'b1, 12'b0000_1111_1001, 1'b0);

    begin_frame(1'b0, 1'b0);
    feed(12'b0000_0000_0111, 3, 1'b0);
    run(1'b1, 12'b1011_0110_1011, 1'b0);
    check("R2 restart mid-frame", crc_o, 4'b0000);

    begin_frame(1'b0, 1'b1);
    feed(12'b0000_1011_0110, 8, 1'b0);
    check("R3 bit with start ignored", crc_o, 4'b1011);

    for (int k = 0; k < 40; k++) begin
      logic chk;
      chk = $urandom_range(0, 1);
      run(chk, 12'($urandom), 1'b1);
      idle($urandom_range(0, 2));
    end

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule